// File: doc/BRIEF.md
# Mip Chain Offset Walker

This block finds where one mip level sits inside a single surface that holds the whole mip chain. It then shifts a texel coordinate into that level. Levels 1 and 2 are placed directly under level 0. Level 2 sits to the right of level 1. Each level from 3 upward is stacked under the level before it. Every level height is rounded up to a vertical alignment before it adds to the vertical offset. Because of that rounding, a closed-form sum cannot be used, so the block walks the chain one level per clock.

A request is taken on `start` while the block is idle. The request gives:
- the unaligned base width and base height,
- a level of detail and a base-level bias,
- an alignment-mode select,
- the incoming coordinate.

When the walk ends, `done` pulses for one cycle. At that point the offsets and the shifted coordinate are valid. The level of detail passed onward is zero, because the shifted coordinate already points into the right level.

Top module: `mip_chain_offset`

## Requirements
- R1: The effective level is `lod + lod_bias`, computed as a 5-bit sum that never wraps (range 0 to 30).
- R2: For an effective level of 0, `off_x` and `off_y` are 0, `out_x` equals `coord_x` and `out_y` equals `coord_y`.
- R3: For effective levels 1 and 2, `off_y` is the base height rounded up to the vertical alignment.
- R4: The vertical alignment is 4 when `align_narrow` is 1 and 8 when it is 0. Rounding of a value v to alignment a is `(v + a - 1) & ~(a - 1)`, taken in 16 bits.
- R5: For an effective level L above 2, the walk works as follows:
  - Start from `off_y` as given by R3 and a current height of `base_h >> 2`.
  - Repeat L-2 times: add the aligned current height to `off_y`, then halve the current height.
  - All sums wrap at 16 bits.
- R6: `off_x` is 0 for effective levels 0 and 1. For level 2 and above it is `base_w >> 1` rounded up to a multiple of 8.
- R7: `out_x = coord_x + off_x` and `out_y = coord_y + off_y`, both modulo 2^16. `out_lod` is always 0.
- R8: The cycles are as follows:
  - `busy` rises on the clock edge that accepts `start`.
  - `done` is high for exactly one cycle, which is 1 + max(L-2, 0) clock edges after the accepting edge.
  - `busy` is low in that same cycle.
- R9: A `start` seen while `busy` is high is ignored. It does not change the result in progress and produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| align_narrow | input | 1 | 1: vertical alignment 4, 0: vertical alignment 8 |
| base_w | input | 16 | Unaligned base level width |
| base_h | input | 16 | Unaligned base level height |
| lod | input | 4 | Requested level of detail |
| lod_bias | input | 4 | Base-level bias added to `lod` |
| coord_x | input | 16 | Incoming x coordinate |
| coord_y | input | 16 | Incoming y coordinate |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| off_x | output | 16 | Horizontal offset of the level |
| off_y | output | 16 | Vertical offset of the level |
| out_x | output | 16 | Shifted x coordinate |
| out_y | output | 16 | Shifted y coordinate |
| out_lod | output | 4 | Level of detail passed onward, always 0 |

## Verification
The bench builds the block with its default 16-bit data width and 4-bit level width. With these values the deepest walk is reachable: `lod` and `lod_bias` both at 15 give 28 iterations. The 16-bit values also make wraparound reachable, both in the rounding mask and in the coordinate sums, when sizes near 65535 are used. Levels 0 to 10 are swept in both alignment modes for power-of-two, odd and extreme base sizes, and random requests with nonzero bias are mixed in.

// File: rtl/mip_chain_offset.sv
module mip_chain_offset #(
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          align_narrow,
  input  logic [DW-1:0] base_w,
  input  logic [DW-1:0] base_h,
  input  logic [LW-1:0] lod,
  input  logic [LW-1:0] lod_bias,
  input  logic [DW-1:0] coord_x,
  input  logic [DW-1:0] coord_y,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] off_x,
  output logic [DW-1:0] off_y,
  output logic [DW-1:0] out_x,
  output logic [DW-1:0] out_y,
  output logic [LW-1:0] out_lod
);
  localparam int EW = LW + 1;

  function automatic logic [DW-1:0] round_up(input logic [DW-1:0] v, input logic narrow);
    logic [DW-1:0] m;
    m = narrow ? DW'(3) : DW'(7);
    return (v + m) & ~m;
  endfunction

  logic [EW-1:0] eff_lvl;
  logic [EW-1:0] lvl_q;
  logic [DW-1:0] cur_h, acc_x, acc_y, cx_q, cy_q;
  logic          narrow_q, zero_q;
  logic          busy_q, done_q;

  assign eff_lvl = EW'(lod) + EW'(lod_bias);
  assign busy    = busy_q;
  assign done    = done_q;
  assign out_lod = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; lvl_q <= '0; cur_h <= '0;
      acc_x <= '0; acc_y <= '0; cx_q <= '0; cy_q <= '0;
      narrow_q <= 1'b0; zero_q <= 1'b0;
      off_x <= '0; off_y <= '0; out_x <= '0; out_y <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q   <= 1'b1;
          lvl_q    <= eff_lvl;
          cur_h    <= base_h >> 2;
          acc_y    <= (eff_lvl != '0) ? round_up(base_h, align_narrow) : '0;
          acc_x    <= (eff_lvl >= EW'(2)) ? round_up(base_w >> 1, 1'b0) : '0;
          cx_q     <= coord_x;
          cy_q     <= coord_y;
          narrow_q <= align_narrow;
          zero_q   <= (eff_lvl == '0);
        end
      end else if (lvl_q <= EW'(2)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        off_x  <= acc_x;
        off_y  <= acc_y;
        out_x  <= cx_q + acc_x;
        out_y  <= cy_q + acc_y;
      end else begin
        acc_y <= acc_y + round_up(cur_h, narrow_q);
        cur_h <= cur_h >> 1;
        lvl_q <= lvl_q - EW'(1);
      end
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_level_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_q) |-> (off_x == '0 && off_y == '0));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(cx_q) && $stable(cy_q) && $stable(narrow_q)));
  assert_walk_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lvl_q > EW'(2)) |=> (busy && lvl_q == $past(lvl_q) - EW'(1)));
  assert_x_level_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lvl_q < EW'(2)) |-> acc_x == '0);
endmodule

// File: tb/sim_mip_chain_offset.sv
module sim_mip_chain_offset;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, align_narrow = 0;
  logic [15:0] base_w = 0, base_h = 0, coord_x = 0, coord_y = 0;
  logic [3:0] lod = 0, lod_bias = 0;
  logic busy, done;
  logic [15:0] off_x, off_y, out_x, out_y;
  logic [3:0] out_lod;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mip_chain_offset u0 (.clk, .rst_n, .start, .align_narrow, .base_w, .base_h,
    .lod, .lod_bias, .coord_x, .coord_y, .busy, .done, .off_x, .off_y,
    .out_x, .out_y, .out_lod);

  function automatic logic [15:0] al(input logic [15:0] v, input bit narrow);
    logic [15:0] m = narrow ? 16'd3 : 16'd7;
    return (v + m) & ~m;
  endfunction

  function automatic logic [15:0] ref_y(input logic [15:0] h, input int lvl, input bit narrow);
    logic [15:0] y, c;
    y = (lvl > 0) ? al(h, narrow) : 16'd0;
    c = h >> 2;
    for (int l = lvl; l > 2; l--) begin
      y = y + al(c, narrow);
      c = c >> 1;
    end
    return y;
  endfunction

  function automatic logic [15:0] ref_x(input logic [15:0] w, input int lvl);
    return (lvl >= 2) ? al(w >> 1, 1'b0) : 16'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] w, input logic [15:0] h, input logic [3:0] l,
                     input logic [3:0] b, input bit narrow, input logic [15:0] cx,
                     input logic [15:0] cy, input bit poke);
    int lvl, cnt, exp_cnt;
    logic [15:0] ex, ey;
    lvl = int'(l) + int'(b);
    ex = ref_x(w, lvl);
    ey = ref_y(h, lvl, narrow);
    exp_cnt = 1 + ((lvl > 2) ? lvl - 2 : 0);
    @(negedge clk);
    base_w = w; base_h = h; lod = l; lod_bias = b; align_narrow = narrow;
    coord_x = cx; coord_y = cy; start = 1;
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    if (poke) begin
      base_w = ~w; base_h = ~h; lod = 4'd1; lod_bias = 4'd0;
      align_narrow = ~narrow; coord_x = cx ^ 16'h5a5a; coord_y = cy ^ 16'h0f0f;
    end else start = 0;
    cnt = 0;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    start = 0;
    chk(cnt == exp_cnt, "R8 latency", cnt, exp_cnt);
    chk(off_x == ex, "R6 off_x", off_x, ex);
    chk(off_y == ey, lvl <= 2 ? "R3/R4 off_y low level" : "R5/R4 off_y walk", off_y, ey);
    chk(out_x == 16'(cx + ex), "R7 out_x", out_x, 16'(cx + ex));
    chk(out_y == 16'(cy + ey), "R7 out_y", out_y, 16'(cy + ey));
    chk(out_lod == 0, "R7 out_lod", out_lod, 0);
    if (lvl == 0) chk(out_x == cx && out_y == cy, "R2 passthrough", out_y, cy);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    if (poke) chk(busy == 1'b0 && done == 1'b0, "R9 start ignored while busy", busy, 0);
  endtask

  initial begin
    logic [15:0] ws[6] = '{16'd64, 16'd100, 16'd1023, 16'd8, 16'd1, 16'd65535};
    logic [15:0] hs[6] = '{16'd64, 16'd37, 16'd517, 16'd8, 16'd3, 16'd65532};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && off_x == 0 && off_y == 0 && out_lod == 0,
        "R8 reset state", busy, 0);
    rst_n = 1;
    for (int s = 0; s < 6; s++)
      for (int n = 0; n < 2; n++)
        for (int l = 0; l <= 10; l++)
          run(ws[s], hs[s], 4'(l), 4'd0, bit'(n), 16'(s * 97), 16'(l * 13), 1'b0);
    // R1: bias contributes to effective level; max level 30
    run(16'd300, 16'd300, 4'd15, 4'd15, 1'b0, 16'd5, 16'd6, 1'b0);
    run(16'd300, 16'd300, 4'd0, 4'd3, 1'b1, 16'd5, 16'd6, 1'b0);
    run(16'd300, 16'd300, 4'd0, 4'd0, 1'b1, 16'hffff, 16'hfffe, 1'b0);
    // R9: restart attempts during the walk
    run(16'd640, 16'd480, 4'd10, 4'd0, 1'b0, 16'd1, 16'd2, 1'b1);
    run(16'd77, 16'd53, 4'd2, 4'd3, 1'b1, 16'd9, 16'd4, 1'b1);
    for (int r = 0; r < 40; r++)
      run(16'($urandom), 16'($urandom), 4'($urandom), 4'($urandom_range(0, 4)),
          bit'($urandom), 16'($urandom), 16'($urandom), bit'($urandom));
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule